// File: doc/BRIEF.md
# Bytecode Pair Fetch Unit

This block sits between a word-addressed instruction memory and the opcode decoder of a stack-machine interpreter. Every 16-bit memory word carries two byte-sized opcodes. The unit holds a word program counter and a one-byte holding register for the opcode that has not yet run. It hands the decoder one opcode per handshake. After each opcode the decoder sends one command. The command asks for the next opcode, a jump, a masked variant of either, or an operand of one byte or one word that follows the opcode.

The holding register is also the "fetch a new word" flag. When it is zero, the next opcode request reads a new word. When it is nonzero, its byte is used directly. A pending interrupt is examined only when a new word is about to be read for an opcode. If the interrupt is taken, the unit skips the read and backs the counter up by one word. It then leaves the holding register as a marker: zero when it stopped at an even byte, nonzero when it stopped at an odd byte. After that it halts until the next start pulse, which resumes at the right byte.

Top module: `bytepair_fetch`

## Requirements
- R1: After reset `pc_o` and `buf_o` are zero, and `op_valid_o` and `cmd_ready_o` are low until a start pulse. A start pulse reads word `pc_o+1` and loads it into `pc_o`. The unit then offers the high byte if `buf_o` was zero, or only the low byte if `buf_o` was nonzero.
- R2: Command codes on `cmd_kind_i` are: 0 next, 1 next with the interrupt check masked, 2 jump, 3 jump masked, 4 byte operand, 5 word operand. On a next command with an empty holding register, the unit reads word `pc_o+1` and advances `pc_o` to it. It offers the high byte (bits 15:8) as the opcode and keeps the low byte (bits 7:0) in `buf_o`.
- R3: A next command with a nonzero `buf_o` offers that byte as the opcode without a memory read and clears `buf_o`.
- R4: A low byte of value 0 leaves the holding register empty, so the following next command reads a new word. A high byte of value 0 (no-operation) is still offered as an opcode.
- R5: A jump reads word `jump_word_i` and sets `pc_o` to it. With `jump_odd_i`=1 only the low byte is offered and `buf_o` ends empty. With `jump_odd_i`=0 it behaves like R2.
- R6: For commands 0 and 2, the interrupt is checked only when a new word would be read. It is taken only when `irq_pend_i` is high and `wake_dis_i` is zero. A byte served from the holding register never takes it.
- R7: A taken interrupt issues no memory read and pulses `irq_take_o`. It sets `pc_o` to the word that would have been read minus 1. `buf_o` becomes 0 for an even stop and nonzero for an odd-byte jump. The unit then waits for a start pulse (R1), which resumes at the skipped byte.
- R8: Commands 1, 3, 4 and 5 never take an interrupt, whatever `irq_pend_i` and `wake_dis_i` are.
- R9: A byte operand is taken from a nonzero `buf_o`, which is then cleared. Otherwise word `pc_o+1` is read, `pc_o` advances, the low byte is returned on `opnd_word_o` and the high byte is kept in `buf_o`.
- R10: A word operand reads word `pc_o+1`, advances `pc_o`, returns the whole word and empties `buf_o`.
- R11: An offered opcode stays stable until `op_ready_i`. Commands are accepted only while `cmd_ready_o` is high. Memory reads occur only on an accepted command or a start pulse. Command codes 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start or resume pulse, used while halted |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Unit can accept a command |
| cmd_kind_i | input | 3 | Command code (R2) |
| jump_word_i | input | AW | Jump target word address |
| jump_odd_i | input | 1 | Jump target is the low (odd) byte |
| op_valid_o | output | 1 | Opcode offered |
| op_ready_i | input | 1 | Decoder accepts the opcode |
| op_byte_o | output | BYTE_W | Opcode |
| opnd_valid_o | output | 1 | One-cycle pulse: operand valid |
| opnd_word_o | output | 2*BYTE_W | Operand (byte operands zero-extended) |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory word address |
| mem_rdata_i | input | 2*BYTE_W | Read data, one cycle after the request |
| irq_pend_i | input | 1 | Interrupt pending |
| wake_dis_i | input | WDC_W | Wakeup-disable count; nonzero blocks interrupts |
| irq_take_o | output | 1 | One-cycle pulse: interrupt taken, unit halted |
| pc_o | output | AW | Word program counter |
| buf_o | output | BYTE_W | Holding register / resume marker |

## Verification
Some rules are checked on every cycle. A masked command never leads to a taken interrupt, and a taken interrupt always follows an enabled request. A jump reads its target address, and a buffered next command reads no memory. Reads follow only accepted commands or starts, and an offered opcode stays stable. A word operand empties the holding register. Other behaviour needs scenarios with known memory contents. These are the byte order within a word, the skip over a zero low byte, the value of a byte operand that crosses into a new word, the backed-up counter and even/odd marker after a taken interrupt, and a correct resume from each marker.

// File: rtl/bytepair_fetch_pkg.sv
package bytepair_fetch_pkg;

   typedef enum logic [2:0] {
      CMD_NEXT      = 3'd0,
      CMD_NEXT_MASK = 3'd1,
      CMD_JUMP      = 3'd2,
      CMD_JUMP_MASK = 3'd3,
      CMD_BYTE      = 3'd4,
      CMD_WORD      = 3'd5
   } cmd_e;

   typedef enum logic [2:0] {
      ST_HALT,
      ST_WAIT,
      ST_RD_OP,
      ST_RD_BYTE,
      ST_RD_WORD,
      ST_OFFER
   } state_e;

   typedef enum logic [1:0] {
      PC_HOLD,
      PC_LOAD,
      PC_BACK
   } pc_op_e;

   typedef enum logic [1:0] {
      HB_HOLD,
      HB_CLEAR,
      HB_LOAD
   } hb_op_e;

endpackage

// File: rtl/fetch_pc.sv
module fetch_pc
   import bytepair_fetch_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  pc_op_e        op_i,
   input  logic [AW-1:0] val_i,
   output logic [AW-1:0] pc_o,
   output logic [AW-1:0] pc_inc_o
);
   localparam logic [AW-1:0] ONE = AW'(1);

   logic [AW-1:0] pc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
      end else begin
         unique case (op_i)
            PC_LOAD: pc_q <= val_i;
            PC_BACK: pc_q <= val_i - ONE;
            default: pc_q <= pc_q;
         endcase
      end
   end

   assign pc_o     = pc_q;
   assign pc_inc_o = pc_q + ONE;
endmodule

// File: rtl/fetch_bytebuf.sv
module fetch_bytebuf
   import bytepair_fetch_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  hb_op_e            op_i,
   input  logic [BYTE_W-1:0] val_i,
   output logic [BYTE_W-1:0] byte_o,
   output logic              pend_o
);
   logic [BYTE_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else begin
         unique case (op_i)
            HB_CLEAR: hold_q <= '0;
            HB_LOAD:  hold_q <= val_i;
            default:  hold_q <= hold_q;
         endcase
      end
   end

   assign byte_o = hold_q;
   // a zero byte doubles as "nothing held"
   assign pend_o = |hold_q;
endmodule

// File: rtl/fetch_irq_gate.sv
module fetch_irq_gate #(
   parameter int WDC_W = 4
) (
   input  logic             check_i,
   input  logic             pend_i,
   input  logic [WDC_W-1:0] wake_dis_i,
   output logic             take_o
);
   assign take_o = check_i && pend_i && (wake_dis_i == '0);
endmodule

// File: rtl/bytepair_fetch.sv
module bytepair_fetch
   import bytepair_fetch_pkg::*;
#(
   parameter int AW      = 16,
   parameter int BYTE_W  = 8,
   parameter int WDC_W   = 4,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic                  cmd_valid_i,
   output logic                  cmd_ready_o,
   input  logic [2:0]            cmd_kind_i,
   input  logic [AW-1:0]         jump_word_i,
   input  logic                  jump_odd_i,
   output logic                  op_valid_o,
   input  logic                  op_ready_i,
   output logic [BYTE_W-1:0]     op_byte_o,
   output logic                  opnd_valid_o,
   output logic [2*BYTE_W-1:0]   opnd_word_o,
   output logic                  mem_req_o,
   output logic [AW-1:0]         mem_addr_o,
   input  logic [2*BYTE_W-1:0]   mem_rdata_i,
   input  logic                  irq_pend_i,
   input  logic [WDC_W-1:0]      wake_dis_i,
   output logic                  irq_take_o,
   output logic [AW-1:0]         pc_o,
   output logic [BYTE_W-1:0]     buf_o
);
   localparam int WORD_W = 2 * BYTE_W;

   if (AW < 2) begin : g_bad_aw
      $error("bytepair_fetch: AW must be at least 2");
   end
   if (BYTE_W < 4) begin : g_bad_bw
      $error("bytepair_fetch: BYTE_W must be at least 4");
   end
   if (WDC_W < 1) begin : g_bad_wdc
      $error("bytepair_fetch: WDC_W must be at least 1");
   end

   state_e              state_q, state_d;
   logic                odd_q, odd_d;
   logic [BYTE_W-1:0]   op_q, op_d;
   logic                op_ld;
   logic [WORD_W-1:0]   opnd_q, opnd_d;
   logic                opnd_ld;
   logic                opnd_v_q;
   logic                take_q;

   pc_op_e              pc_op;
   logic [AW-1:0]       pc_val;
   logic [AW-1:0]       pc_cur, pc_inc;
   hb_op_e              hb_op;
   logic [BYTE_W-1:0]   hb_val;
   logic [BYTE_W-1:0]   hb_cur;
   logic                hb_pend;

   logic [BYTE_W-1:0]   rd_hi, rd_lo;
   logic                cmd_fire;
   cmd_e                kind;
   logic                chk_irq;
   logic                irq_pend_s;
   logic [WDC_W-1:0]    wake_dis_s;
   logic                take;

   fetch_pc #(.AW(AW)) u_pc (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_i     (pc_op),
      .val_i    (pc_val),
      .pc_o     (pc_cur),
      .pc_inc_o (pc_inc)
   );

   fetch_bytebuf #(.BYTE_W(BYTE_W)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .op_i   (hb_op),
      .val_i  (hb_val),
      .byte_o (hb_cur),
      .pend_o (hb_pend)
   );

   // interrupt inputs used either directly or after one register stage
   if (IRQ_REG) begin : g_irq_reg
      logic             pend_q;
      logic [WDC_W-1:0] wdc_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q <= 1'b0;
            wdc_q  <= '0;
         end else begin
            pend_q <= irq_pend_i;
            wdc_q  <= wake_dis_i;
         end
      end
      assign irq_pend_s = pend_q;
      assign wake_dis_s = wdc_q;
   end else begin : g_irq_direct
      assign irq_pend_s = irq_pend_i;
      assign wake_dis_s = wake_dis_i;
   end

   fetch_irq_gate #(.WDC_W(WDC_W)) u_gate (
      .check_i    (chk_irq),
      .pend_i     (irq_pend_s),
      .wake_dis_i (wake_dis_s),
      .take_o     (take)
   );

   assign rd_hi    = mem_rdata_i[WORD_W-1:BYTE_W];
   assign rd_lo    = mem_rdata_i[BYTE_W-1:0];
   assign cmd_fire = (state_q == ST_WAIT) && cmd_valid_i;
   assign kind     = cmd_e'(cmd_kind_i);

   // check only unmasked next/jump that really need a new word
   assign chk_irq = cmd_fire &&
                    ((kind == CMD_JUMP) || ((kind == CMD_NEXT) && !hb_pend));

   always_comb begin
      state_d    = state_q;
      odd_d      = odd_q;
      op_ld      = 1'b0;
      op_d       = op_q;
      opnd_ld    = 1'b0;
      opnd_d     = opnd_q;
      pc_op      = PC_HOLD;
      pc_val     = pc_inc;
      hb_op      = HB_HOLD;
      hb_val     = '0;
      mem_req_o  = 1'b0;
      mem_addr_o = pc_inc;

      unique case (state_q)
         ST_HALT: begin
            if (start_i) begin
               mem_req_o  = 1'b1;
               mem_addr_o = pc_inc;
               pc_op      = PC_LOAD;
               pc_val     = pc_inc;
               odd_d      = hb_pend;
               hb_op      = HB_CLEAR;
               state_d    = ST_RD_OP;
            end
         end

         ST_WAIT: begin
            if (cmd_valid_i) begin
               case (kind)
                  CMD_NEXT, CMD_NEXT_MASK: begin
                     if (hb_pend) begin
                        op_ld   = 1'b1;
                        op_d    = hb_cur;
                        hb_op   = HB_CLEAR;
                        state_d = ST_OFFER;
                     end else if (take) begin
                        state_d = ST_HALT;
                     end else begin
                        mem_req_o  = 1'b1;
                        mem_addr_o = pc_inc;
                        pc_op      = PC_LOAD;
                        pc_val     = pc_inc;
                        odd_d      = 1'b0;
                        state_d    = ST_RD_OP;
                     end
                  end
                  CMD_JUMP, CMD_JUMP_MASK: begin
                     if (take) begin
                        pc_op   = PC_BACK;
                        pc_val  = jump_word_i;
                        hb_op   = HB_LOAD;
                        hb_val  = {{(BYTE_W-1){1'b0}}, jump_odd_i};
                        state_d = ST_HALT;
                     end else begin
                        mem_req_o  = 1'b1;
                        mem_addr_o = jump_word_i;
                        pc_op      = PC_LOAD;
                        pc_val     = jump_word_i;
                        odd_d      = jump_odd_i;
                        hb_op      = HB_CLEAR;
                        state_d    = ST_RD_OP;
                     end
                  end
                  CMD_BYTE: begin
                     if (hb_pend) begin
                        opnd_ld = 1'b1;
                        opnd_d  = {{BYTE_W{1'b0}}, hb_cur};
                        hb_op   = HB_CLEAR;
                     end else begin
                        mem_req_o  = 1'b1;
                        mem_addr_o = pc_inc;
                        pc_op      = PC_LOAD;
                        pc_val     = pc_inc;
                        state_d    = ST_RD_BYTE;
                     end
                  end
                  CMD_WORD: begin
                     mem_req_o  = 1'b1;
                     mem_addr_o = pc_inc;
                     pc_op      = PC_LOAD;
                     pc_val     = pc_inc;
                     hb_op      = HB_CLEAR;
                     state_d    = ST_RD_WORD;
                  end
                  default: begin
                     state_d = ST_WAIT;
                  end
               endcase
            end
         end

         ST_RD_OP: begin
            op_ld = 1'b1;
            if (odd_q) begin
               op_d  = rd_lo;
               hb_op = HB_CLEAR;
            end else begin
               op_d   = rd_hi;
               hb_op  = HB_LOAD;
               hb_val = rd_lo;
            end
            odd_d   = 1'b0;
            state_d = ST_OFFER;
         end

         ST_RD_BYTE: begin
            opnd_ld = 1'b1;
            opnd_d  = {{BYTE_W{1'b0}}, rd_lo};
            hb_op   = HB_LOAD;
            hb_val  = rd_hi;
            state_d = ST_WAIT;
         end

         ST_RD_WORD: begin
            opnd_ld = 1'b1;
            opnd_d  = mem_rdata_i;
            state_d = ST_WAIT;
         end

         ST_OFFER: begin
            if (op_ready_i) begin
               state_d = ST_WAIT;
            end
         end

         default: begin
            state_d = ST_HALT;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_HALT;
         odd_q    <= 1'b0;
         op_q     <= '0;
         opnd_q   <= '0;
         opnd_v_q <= 1'b0;
         take_q   <= 1'b0;
      end else begin
         state_q  <= state_d;
         odd_q    <= odd_d;
         opnd_v_q <= opnd_ld;
         take_q   <= take;
         if (op_ld) begin
            op_q <= op_d;
         end
         if (opnd_ld) begin
            opnd_q <= opnd_d;
         end
      end
   end

   assign cmd_ready_o  = (state_q == ST_WAIT);
   assign op_valid_o   = (state_q == ST_OFFER);
   assign op_byte_o    = op_q;
   assign opnd_valid_o = opnd_v_q;
   assign opnd_word_o  = opnd_q;
   assign irq_take_o   = take_q;
   assign pc_o         = pc_cur;
   assign buf_o        = hb_cur;
endmodule

// File: rtl/bytepair_fetch_chk.sv
module bytepair_fetch_chk #(
   parameter int AW      = 16,
   parameter int BYTE_W  = 8,
   parameter int WDC_W   = 4,
   parameter bit IRQ_REG = 1'b0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start_i,
   input logic                cmd_valid_i,
   input logic                cmd_ready_o,
   input logic [2:0]          cmd_kind_i,
   input logic [AW-1:0]       jump_word_i,
   input logic                op_valid_o,
   input logic                op_ready_i,
   input logic [BYTE_W-1:0]   op_byte_o,
   input logic                mem_req_o,
   input logic [AW-1:0]       mem_addr_o,
   input logic                irq_pend_i,
   input logic [WDC_W-1:0]    wake_dis_i,
   input logic                irq_take_o,
   input logic [BYTE_W-1:0]   buf_o
);
   logic fire;
   logic masked_kind;
   assign fire        = cmd_valid_i && cmd_ready_o;
   assign masked_kind = (cmd_kind_i == 3'd1) || (cmd_kind_i == 3'd3) ||
                        (cmd_kind_i == 3'd4) || (cmd_kind_i == 3'd5);

   AST_REQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> (fire || start_i)); // R11

   AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_o && !op_ready_i) |=> (op_valid_o && $stable(op_byte_o))); // R11

   AST_TAKE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take_o |-> (!cmd_ready_o && !op_valid_o)); // R7

   AST_MASKED_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && masked_kind) |=> !irq_take_o); // R8

   AST_JUMP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (cmd_kind_i[2:1] == 2'b01) && mem_req_o) |-> (mem_addr_o == jump_word_i)); // R5

   AST_HELD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (cmd_kind_i[2:1] == 2'b00) && (buf_o != '0)) |-> !mem_req_o); // R3

   AST_WORD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (cmd_kind_i == 3'd5)) |=> (buf_o == '0)); // R10

   if (IRQ_REG) begin : g_chk_reg
      AST_TAKE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
         irq_take_o |-> $past(irq_pend_i && (wake_dis_i == '0), 2)); // R6
   end else begin : g_chk_direct
      AST_TAKE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
         irq_take_o |-> $past(irq_pend_i && (wake_dis_i == '0))); // R6
   end
endmodule

bind bytepair_fetch bytepair_fetch_chk #(
   .AW(AW), .BYTE_W(BYTE_W), .WDC_W(WDC_W), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .cmd_valid_i (cmd_valid_i),
   .cmd_ready_o (cmd_ready_o),
   .cmd_kind_i  (cmd_kind_i),
   .jump_word_i (jump_word_i),
   .op_valid_o  (op_valid_o),
   .op_ready_i  (op_ready_i),
   .op_byte_o   (op_byte_o),
   .mem_req_o   (mem_req_o),
   .mem_addr_o  (mem_addr_o),
   .irq_pend_i  (irq_pend_i),
   .wake_dis_i  (wake_dis_i),
   .irq_take_o  (irq_take_o),
   .buf_o       (buf_o)
);

// File: tb/bytepair_fetch_tb.sv
`timescale 1ns/1ps
module bytepair_fetch_tb;
   localparam int AW = 16;
   localparam int BW = 8;
   localparam int WW = 16;
   localparam int WD = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          cmd_valid_i = 1'b0;
   logic          cmd_ready_o;
   logic [2:0]    cmd_kind_i = '0;
   logic [AW-1:0] jump_word_i = '0;
   logic          jump_odd_i = 1'b0;
   logic          op_valid_o;
   logic          op_ready_i = 1'b0;
   logic [BW-1:0] op_byte_o;
   logic          opnd_valid_o;
   logic [WW-1:0] opnd_word_o;
   logic          mem_req_o;
   logic [AW-1:0] mem_addr_o;
   logic [WW-1:0] mem_rdata_i = '0;
   logic          irq_pend_i = 1'b0;
   logic [WD-1:0] wake_dis_i = '0;
   logic          irq_take_o;
   logic [AW-1:0] pc_o;
   logic [BW-1:0] buf_o;

   int checks = 0;
   int errors = 0;
   int take_cnt = 0;
   int req_cnt = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   bytepair_fetch u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o), .cmd_kind_i(cmd_kind_i),
      .jump_word_i(jump_word_i), .jump_odd_i(jump_odd_i),
      .op_valid_o(op_valid_o), .op_ready_i(op_ready_i), .op_byte_o(op_byte_o),
      .opnd_valid_o(opnd_valid_o), .opnd_word_o(opnd_word_o),
      .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
      .irq_pend_i(irq_pend_i), .wake_dis_i(wake_dis_i), .irq_take_o(irq_take_o),
      .pc_o(pc_o), .buf_o(buf_o)
   );

   // memory image: high byte = low 8 address bits, low byte = that xor A5
   function automatic logic [WW-1:0] mem_word(input logic [AW-1:0] a);
      return {a[7:0], a[7:0] ^ 8'hA5};
   endfunction

   always @(posedge clk) begin
      if (mem_req_o) begin
         mem_rdata_i <= mem_word(mem_addr_o);
         req_cnt <= req_cnt + 1;
      end
      if (irq_take_o) take_cnt <= take_cnt + 1;
   end

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic send_cmd(input logic [2:0] k, input logic [AW-1:0] tgt, input logic odd);
      int n = 0;
      @(negedge clk);
      while (!cmd_ready_o && n < 50) begin
         @(negedge clk);
         n++;
      end
      cmd_kind_i  = k;
      jump_word_i = tgt;
      jump_odd_i  = odd;
      cmd_valid_i = 1'b1;
      @(negedge clk);
      cmd_valid_i = 1'b0;
   endtask

   task automatic get_op(output logic [BW-1:0] v);
      int n = 0;
      while (!op_valid_o && n < 50) begin
         @(negedge clk);
         n++;
      end
      v = op_valid_o ? op_byte_o : 8'hXX;
      op_ready_i = 1'b1;
      @(negedge clk);
      op_ready_i = 1'b0;
   endtask

   task automatic get_opnd(output logic [WW-1:0] v);
      int n = 0;
      while (!opnd_valid_o && n < 50) begin
         @(negedge clk);
         n++;
      end
      v = opnd_valid_o ? opnd_word_o : 16'hXXXX;
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   typedef struct packed {
      logic [2:0]  kind;
      logic [15:0] tgt;
      logic        odd;
      logic [15:0] expv;
      logic [15:0] expc;
   } vec_t;

   // R2 R3 R4 R5 R9 R10 sequence, starting after start: pc=1, held byte A4
   localparam vec_t VEC [17] = '{
      '{3'd0, 16'h0000, 1'b0, 16'h00A4, 16'h0001},  // R3 held byte
      '{3'd0, 16'h0000, 1'b0, 16'h0002, 16'h0002},  // R2 new word
      '{3'd4, 16'h0000, 1'b0, 16'h00A7, 16'h0002},  // R9 held byte
      '{3'd4, 16'h0000, 1'b0, 16'h00A6, 16'h0003},  // R9 new word low byte
      '{3'd0, 16'h0000, 1'b0, 16'h0003, 16'h0003},  // R9 high byte kept
      '{3'd5, 16'h0000, 1'b0, 16'h04A1, 16'h0004},  // R10
      '{3'd0, 16'h0000, 1'b0, 16'h0005, 16'h0005},  // R10 next reads new word
      '{3'd2, 16'h0010, 1'b1, 16'h00B5, 16'h0010},  // R5 odd jump
      '{3'd0, 16'h0000, 1'b0, 16'h0011, 16'h0011},  // R5 buffer left empty
      '{3'd2, 16'h00A5, 1'b0, 16'h00A5, 16'h00A5},  // R5 even jump, low byte 0
      '{3'd0, 16'h0000, 1'b0, 16'h00A6, 16'h00A6},  // R4 zero low byte skipped
      '{3'd2, 16'h0000, 1'b1, 16'h00A5, 16'h0000},  // R5 odd jump to word 0
      '{3'd0, 16'h0000, 1'b0, 16'h0001, 16'h0001},  // R2
      '{3'd1, 16'h0000, 1'b0, 16'h00A4, 16'h0001},  // R3 masked next held
      '{3'd2, 16'h0000, 1'b0, 16'h0000, 16'h0000},  // R4 NOOP high byte offered
      '{3'd5, 16'h0000, 1'b0, 16'h01A4, 16'h0001},  // R10
      '{3'd0, 16'h0000, 1'b0, 16'h0002, 16'h0002}   // R10 next from new word
   };

   initial begin
      logic [BW-1:0] ob;
      logic [WW-1:0] ow;
      int tk;
      int rq;

      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 pc after reset", pc_o, 0);
      check("R1 buf after reset", buf_o, 0);
      check("R1 op_valid idle", op_valid_o, 0);
      check("R1 cmd_ready idle", cmd_ready_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 still halted before start", cmd_ready_o, 0);
      pulse_start();
      get_op(ob);
      check("R1 start opcode", ob, 8'h01);
      check("R1 start pc", pc_o, 1);

      for (int i = 0; i < 17; i++) begin
         send_cmd(VEC[i].kind, VEC[i].tgt, VEC[i].odd);
         if (VEC[i].kind >= 3'd4) begin
            get_opnd(ow);
            check($sformatf("R9/R10 vec %0d operand", i), ow, VEC[i].expv);
         end else begin
            get_op(ob);
            check($sformatf("R2-5 vec %0d opcode", i), ob, VEC[i].expv[7:0]);
         end
         check($sformatf("vec %0d pc", i), pc_o, VEC[i].expc);
      end

      // R6 held byte never takes an interrupt (pc=2, held A7)
      irq_pend_i = 1'b1;
      wake_dis_i = '0;
      tk = take_cnt;
      send_cmd(3'd0, '0, 1'b0);
      get_op(ob);
      check("R6 held byte served under irq", ob, 8'hA7);
      check("R6 no take on held byte", take_cnt, tk);

      // R7 take at an even stop
      rq = req_cnt;
      send_cmd(3'd0, '0, 1'b0);
      repeat (3) @(negedge clk);
      check("R7 take pulse", take_cnt, tk + 1);
      check("R7 no memory read", req_cnt, rq);
      check("R7 pc backed up", pc_o, 2);
      check("R7 even marker", buf_o, 0);
      check("R7 halted", cmd_ready_o, 0);
      irq_pend_i = 1'b0;
      pulse_start();
      get_op(ob);
      check("R7 resume even opcode", ob, 8'h03);
      check("R7 resume pc", pc_o, 3);

      // R6 disabled by wakeup-disable count
      send_cmd(3'd4, '0, 1'b0);
      get_opnd(ow);
      check("R9 held operand", ow, 16'h00A6);
      irq_pend_i = 1'b1;
      wake_dis_i = 4'd2;
      tk = take_cnt;
      send_cmd(3'd0, '0, 1'b0);
      get_op(ob);
      check("R6 disabled count blocks take", ob, 8'h04);
      check("R6 no take count", take_cnt, tk);

      // R8 masked commands
      wake_dis_i = '0;
      send_cmd(3'd4, '0, 1'b0);
      get_opnd(ow);
      check("R8 byte operand under irq", ow, 16'h00A1);
      send_cmd(3'd1, '0, 1'b0);
      get_op(ob);
      check("R8 masked next", ob, 8'h05);
      send_cmd(3'd5, '0, 1'b0);
      get_opnd(ow);
      check("R8 word operand under irq", ow, 16'h06A3);
      send_cmd(3'd3, 16'h0020, 1'b1);
      get_op(ob);
      check("R8 masked odd jump", ob, 8'h85);
      check("R8 no takes", take_cnt, tk);

      // R7 take on odd jump, then resume at the odd byte
      send_cmd(3'd2, 16'h0030, 1'b1);
      repeat (3) @(negedge clk);
      check("R7 odd take pulse", take_cnt, tk + 1);
      check("R7 odd pc backed up", pc_o, 16'h002F);
      check("R7 odd marker nonzero", (buf_o != 0), 1);
      irq_pend_i = 1'b0;
      pulse_start();
      get_op(ob);
      check("R7 odd resume opcode", ob, 8'h95);
      check("R7 odd resume pc", pc_o, 16'h0030);
      check("R7 odd resume buf empty", buf_o, 0);

      // R11 opcode held while not ready
      send_cmd(3'd0, '0, 1'b0);
      repeat (3) @(negedge clk);
      check("R11 op offered", op_valid_o, 1);
      check("R11 op value while stalled", op_byte_o, 8'h31);
      repeat (2) @(negedge clk);
      check("R11 op still held", op_byte_o, 8'h31);
      get_op(ob);

      // R11 unused command code ignored
      rq = req_cnt;
      send_cmd(3'd6, '0, 1'b0);
      repeat (3) @(negedge clk);
      check("R11 code 6 no read", req_cnt, rq);
      check("R11 code 6 still ready", cmd_ready_o, 1);
      check("R11 code 6 no opcode", op_valid_o, 0);
      check("R11 code 6 pc unchanged", pc_o, 16'h0031);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule